// File: doc/BRIEF.md
# Spike-Triggered Time Window Generator

This block serves one synapse slot in a spike-timing learning datapath. When a delayed, aligned spike strobe arrives while no window is open, it opens a timed window. It emits a single start pulse and records what kind of spike opened the window (pre-synaptic or post-synaptic) as a polarity bit, with a write strobe for the polarity store.

On start, a down-counter loads the requested window length and then counts toward zero once per cycle. The window is open while the counter is nonzero. The live counter value is exported so that downstream weight-update logic can use it as the size of the weight change.

The open/closed state is also exported as an active flag. This flag passes through a short synchronizer chain, so it trails the internal window state by a fixed number of cycles. A spike that arrives while the window is open is ignored.

Top module: `tw_window_gen`

## Requirements
- R1: A synchronous active-high reset clears `win_start`, `pol_wr`, `win_pol`, `win_active` and `win_count` to 0 at the first clock edge where `rst` is sampled high.
- R2: A spike sampled at a clock edge while `win_count` is 0 makes `win_start` high for exactly the one cycle after that edge.
- R3: `pol_wr` is high in exactly the cycles where `win_start` is high. In those cycles `win_pol` takes the spike type (`spike_post` 0 = pre-synaptic gives 0, 1 = post-synaptic gives 1), and it keeps that value until the next start.
- R4: In the `win_start` cycle, `win_count` shows the window length. After that it drops by exactly 1 every cycle until it reaches 0.
- R5: The window is open, meaning `win_count` is nonzero, for exactly as many cycles as the loaded length. After that `win_count` holds at 0 until the next start.
- R6: The loaded length is `win_len` limited to the range 1 to `MAX_LEN`: a request of 0 loads 1, and a request above `MAX_LEN` loads `MAX_LEN`.
- R7: A spike sampled while `win_count` is nonzero has no effect: there is no start pulse, no reload of the count and no change of polarity.
- R8: `win_active` equals the window-open state (`win_count` nonzero) delayed by `SYNC_STAGES` cycles. With the default of 2, it rises two cycles after `win_start` rises and falls two cycles after `win_count` reaches 0.
- R9: A spike sampled at the first edge where `win_count` is 0 again starts a new window at once, even if the strobe has been held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spike_dly | input | 1 | Delayed aligned spike strobe |
| spike_post | input | 1 | Spike type: 0 pre-synaptic, 1 post-synaptic |
| win_len | input | CNT_W | Requested window length in cycles |
| win_start | output | 1 | One-cycle window start pulse |
| pol_wr | output | 1 | Polarity store write strobe |
| win_pol | output | 1 | Polarity of the window that is open or was last opened |
| win_active | output | 1 | Synchronized window-active flag |
| win_count | output | CNT_W | Live window counter, used as weight-change magnitude |

## Verification
The hardest case to reach is a spike that lands exactly on a window boundary. One form is a spike sampled on the last open cycle, which must be ignored; the other is a spike sampled on the first idle cycle, which must restart the window. The bench gets there by holding the strobe high for many cycles with a short length, so that every boundary edge sees a spike. It also changes the type and length while a window is open, which exposes any reload or polarity overwrite. A cycle-accurate model in the bench predicts every output in every cycle, so a single-cycle slip at any boundary shows up as a mismatch.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic {
    KIND_PRE  = 1'b0,
    KIND_POST = 1'b1
  } spike_kind_e;
endpackage

// File: rtl/tw_trigger.sv
module tw_trigger (
  input  logic clk,
  input  logic rst,
  input  logic spike,
  input  logic busy,
  output logic start_req,
  output logic start_q
);
  // A new window may only begin when the counter is idle.
  always_comb start_req = spike & ~busy;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start_req;
  end

  // R2: the start pulse never lasts two cycles
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
endmodule

// File: rtl/tw_down_counter.sv
module tw_down_counter #(
  parameter int CNT_W   = 8,
  parameter int MAX_LEN = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len_req,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] len_lim;

  always_comb begin
    if (len_req == '0)        len_lim = ONE_V;
    else if (len_req > MAX_V) len_lim = MAX_V;
    else                      len_lim = len_req;
  end

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= len_lim;
    else if (cnt != '0)  cnt <= cnt - ONE_V;
  end

  always_comb busy = (cnt != '0);

  // R6: a freshly loaded window stays within its bounds
  a_r6_len_bounds: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt >= ONE_V && cnt <= MAX_V));

  // R7: an open window only ever counts down, never reloads
  a_r7_no_reload: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - ONE_V));
endmodule

// File: rtl/tw_polarity.sv
module tw_polarity
  import tw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic kind_in,
  output logic pol_q,
  output logic wr_q
);
  spike_kind_e kind;
  always_comb kind = spike_kind_e'(kind_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= wr_req;
      if (wr_req) pol_q <= (kind == KIND_POST);
    end
  end

  // R3: polarity holds between writes
  a_r3_pol_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_req |=> $stable(pol_q));
endmodule

// File: rtl/tw_sync_pipe.sv
module tw_sync_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  always_comb q = stg[STAGES-1];
endmodule

// File: rtl/tw_window_gen.sv
module tw_window_gen #(
  parameter int CNT_W       = 8,
  parameter int MAX_LEN     = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spike_dly,
  input  logic             spike_post,
  input  logic [CNT_W-1:0] win_len,
  output logic             win_start,
  output logic             pol_wr,
  output logic             win_pol,
  output logic             win_active,
  output logic [CNT_W-1:0] win_count
);
  logic busy;
  logic start_req;

  tw_trigger u_trig (
    .clk       (clk),
    .rst       (rst),
    .spike     (spike_dly),
    .busy      (busy),
    .start_req (start_req),
    .start_q   (win_start)
  );

  tw_down_counter #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (start_req),
    .len_req (win_len),
    .cnt     (win_count),
    .busy    (busy)
  );

  tw_polarity u_pol (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (start_req),
    .kind_in (spike_post),
    .pol_q   (win_pol),
    .wr_q    (pol_wr)
  );

  tw_sync_pipe #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (busy),
    .q   (win_active)
  );

  // R3: the store write strobe coincides with the start pulse
  a_r3_wr_with_start: assert property (@(posedge clk) disable iff (rst)
    win_start == pol_wr);

  // R4: the start cycle shows a loaded, nonzero count
  a_r4_start_loaded: assert property (@(posedge clk) disable iff (rst)
    win_start |-> (win_count != '0));
endmodule

// File: tb/tw_window_gen_test.sv
module tw_window_gen_test;
  localparam int CNT_W   = 8;
  localparam int MAX_LEN = 200;
  localparam int SYNC    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spike_dly = 1'b0;
  logic spike_post = 1'b0;
  logic [CNT_W-1:0] win_len = '0;
  logic win_start, pol_wr, win_pol, win_active;
  logic [CNT_W-1:0] win_count;

  always #2 clk = ~clk; // 250 MHz

  tw_window_gen #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .spike_dly(spike_dly), .spike_post(spike_post),
    .win_len(win_len), .win_start(win_start), .pol_wr(pol_wr),
    .win_pol(win_pol), .win_active(win_active), .win_count(win_count)
  );

  typedef struct packed {
    logic             start;
    logic             wr;
    logic             pol;
    logic             act;
    logic [CNT_W-1:0] cnt;
  } exp_t;

  exp_t exp_q[$];
  int compared = 0;
  int mismatched = 0;
  string phase = "R1 reset";

  // Reference model built from the requirements
  int m_cnt = 0;
  logic m_pol = 1'b0;
  logic m_start = 1'b0;
  logic [SYNC-1:0] m_pipe = '0;

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_cnt = 0; m_pol = 1'b0; m_start = 1'b0; m_pipe = '0;
    end else begin
      int lim;
      logic was_busy;
      was_busy = (m_cnt != 0);
      m_pipe = {m_pipe[SYNC-2:0], was_busy};
      m_start = spike_dly && !was_busy;
      if (m_start) begin
        lim = int'(win_len);
        if (lim == 0) lim = 1;           // R6 lower bound
        if (lim > MAX_LEN) lim = MAX_LEN; // R6 upper bound
        m_cnt = lim;
        m_pol = spike_post;
      end else if (m_cnt != 0) begin
        m_cnt = m_cnt - 1;
      end
    end
    e.start = m_start; e.wr = m_start; e.pol = m_pol;
    e.act = m_pipe[SYNC-1]; e.cnt = CNT_W'(m_cnt);
    exp_q.push_back(e);
  end

  task automatic cmp1(string req, logic a, logic x);
    if (a !== x) begin
      mismatched++;
      $display("FAIL %s [%s] actual=%0b expected=%0b t=%0t", req, phase, a, x, $time);
    end
  endtask

  // Monitor: compare on the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compared++;
      cmp1("R2 win_start", win_start, e.start);
      cmp1("R3 pol_wr", pol_wr, e.wr);
      cmp1("R3 win_pol", win_pol, e.pol);
      cmp1("R8 win_active", win_active, e.act);
      if (win_count !== e.cnt) begin
        mismatched++;
        $display("FAIL R4/R5 win_count [%s] actual=%0d expected=%0d t=%0t",
                 phase, win_count, e.cnt, $time);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic spike(logic post, int len, int hold);
    @(negedge clk);
    spike_dly = 1'b1; spike_post = post; win_len = CNT_W'(len);
    idle(hold);
    spike_dly = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    idle(3);
    // R1: reset state at the port
    compared++;
    if (win_start !== 0 || pol_wr !== 0 || win_pol !== 0 || win_active !== 0 || win_count !== 0) begin
      mismatched++;
      $display("FAIL R1 reset outputs actual=%0b%0b%0b%0b/%0d expected=0000/0",
               win_start, pol_wr, win_pol, win_active, win_count);
    end
    rst = 1'b0;
    idle(2);
    phase = "R2 R4 pre spike len5";  spike(1'b0, 5, 1);  idle(10);
    phase = "R3 post spike len3";    spike(1'b1, 3, 1);  idle(8);
    phase = "R3 pre after post";     spike(1'b0, 2, 1);  idle(8);
    phase = "R7 spikes while open";  spike(1'b1, 10, 1); idle(2);
    spike(1'b0, 50, 1); idle(3); spike(1'b0, 1, 2);      idle(12);
    phase = "R6 zero length";        spike(1'b1, 0, 1);  idle(6);
    phase = "R6 over max length";    spike(1'b0, 255, 1); idle(MAX_LEN + 6);
    phase = "R6 exact max";          spike(1'b1, MAX_LEN, 1); idle(MAX_LEN + 6);
    phase = "R9 held strobe len3";   spike(1'b1, 3, 14); idle(8);
    phase = "R9 held strobe len1";   spike(1'b0, 1, 6);  idle(6);
    phase = "R1 mid-run reset";      spike(1'b1, 20, 1); idle(4);
    rst = 1'b1; idle(2); rst = 1'b0; idle(4);
    phase = "R5 after reset";        spike(1'b0, 4, 1);  idle(10);
    finish_run();
  end

  initial begin
    #40000;
    mismatched++;
    $display("FAIL watchdog expired [%s]", phase);
    finish_run();
  end
endmodule